// File: doc/BRIEF.md
# One-of-four pulse-position downlink encoder

This block turns one tag command into a carrier-enable waveform for a low-frequency reader. Every symbol carries two bits, and the value is coded as one of four carrier-on lengths. After each symbol the carrier is off for a fixed gap. A frame has a fixed shape. The carrier is first held on long enough to power the tag, then dropped for a start gap. Next come the symbols: a reference symbol, an opcode, an optional password, and then the write payload or the read address. The frame ends with a long carrier-on hold, during which the tag programs a write or begins its reply to a read.

All durations count pulses on a 1 µs tick input, so the block does not depend on the system clock frequency. The host sets up the command fields and pulses `start_i` while `busy_o` is low. The fields are captured in that cycle. `done_o` pulses once, in the cycle the carrier drops after the final hold. Duration parameters are in microseconds, or in units of `UNIT_US` for the short symbol timings. The defaults give 8 µs units, symbols of 18, 34, 50 and 66 units, a 20-unit gap, a 31-unit start gap, a 5 ms power-up and a 20 ms write hold.

Top module: `lf_ppm_tx`

## Requirements
- R1: After reset `carrier_o`, `busy_o` and `done_o` are low. A `start_i` pulse while idle raises `busy_o` and `carrier_o` in the next cycle, and the carrier then stays on for `T_POWERUP_US` ticks.
- R2: After the power-up the carrier is off for `T_START_GAP*UNIT_US` ticks.
- R3: Each symbol is a carrier-on time followed by `T_GAP*UNIT_US` ticks of carrier off. The on time is `T_SYM00`, `T_SYM01`, `T_SYM10` or `T_SYM11` times `UNIT_US` for codes 00, 01, 10 and 11. In each symbol code, the earlier bit of the stream is the MSB.
- R4: The first symbol is always 00. The second symbol is the opcode: {1, `page_i`} normally, or 01 when `test_i` is high.
- R5: When `pwd_en_i` is high, a 00 symbol follows the opcode. Then 16 symbols carry `pwd_i`, bits 31 and 30 first and bits 1 and 0 last.
- R6: For a write (`write_i`=1), the stream continues with the bits 0, `data_i[31:0]`, `addr_i[2:0]`, which gives 18 symbols. So the first data symbol is {0, data[31]}, and the last two symbols are {data[0], addr[2]} and addr[1:0].
- R7: For a read, the stream continues with 0, `addr_i[2:0]` (2 symbols). If `addr_i` is 8'hFF, both of these symbols are left out.
- R8: After the last symbol gap the carrier is held on before the frame ends. The hold lasts `T_HOLD_WR_US` ticks for a write, `T_HOLD_TEST_US` for a write with `test_i` high, and `T_READ_HOLD*UNIT_US` for a read. The carrier is then off.
- R9: `done_o` is high for exactly one cycle, the cycle in which the carrier drops after the hold. In that cycle `busy_o` is already low, and `busy_o` is high for the whole frame before it.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The frame in progress keeps its symbols and timing, and no second frame follows.
- R11: All durations count `tick_i` pulses and not clock cycles. When the tick comes every third cycle, each interval of N ticks lasts between 3(N-1)+1 and 3N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 µs timing strobe |
| start_i | input | 1 | Start a frame (accepted only while idle) |
| write_i | input | 1 | 1 = write command, 0 = read |
| page_i | input | 1 | Page select, sent in the opcode |
| test_i | input | 1 | Test-mode opcode and test-mode write hold |
| pwd_en_i | input | 1 | Send the password section |
| pwd_i | input | 32 | Password |
| data_i | input | 32 | Write data |
| addr_i | input | 8 | Block address in bits 2:0; 8'hFF means a read without address |
| carrier_o | output | 1 | Carrier enable |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the frame ends |

## Verification
On every cycle, the assertions check the handshake and the framing around the carrier. The carrier is off while idle, `done_o` lasts a single cycle and marks the only way `busy_o` falls, an accepted start brings up the carrier at once, and the carrier changes level only on a tick, a start or a reset. The order and value of the symbols cannot be seen by any single-cycle property. The bench shows them by measuring every carrier run against widths it computes from the command fields. It covers the password, test-mode, read and addressless-read layouts, and it checks a start issued mid-frame and a slowed tick.

// File: rtl/lf_ppm_pkg.sv
package lf_ppm_pkg;
  // stream: ref(2) + opcode(2) + pwd section(2+32) + write payload(1+32+3)
  localparam int MAX_BITS = 2 + 2 + 34 + 36;
  localparam int MAX_SYMS = MAX_BITS / 2;
  localparam int LEN_W    = $clog2(MAX_BITS + 1);
  localparam int SYM_W    = $clog2(MAX_SYMS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_POWER, ST_SGAP, ST_SYM, ST_GAP, ST_HOLD
  } ppm_state_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lf_ppm_pack.sv
// Builds the left-aligned bit stream of one frame and its symbol count.
module lf_ppm_pack
  import lf_ppm_pkg::*;
(
  input  logic                page_i,
  input  logic                test_i,
  input  logic                pwd_en_i,
  input  logic                write_i,
  input  logic [31:0]         pwd_i,
  input  logic [31:0]         data_i,
  input  logic [7:0]          addr_i,
  output logic [MAX_BITS-1:0] bits_o,
  output logic [SYM_W-1:0]    nsym_o
);
  logic [MAX_BITS-1:0] v;
  logic [LEN_W-1:0]    n;

  always_comb begin
    v = '0;
    n = '0;
    v = {v[MAX_BITS-3:0], 2'b00};
    n = n + LEN_W'(2);
    v = {v[MAX_BITS-3:0], (test_i ? 2'b01 : {1'b1, page_i})};
    n = n + LEN_W'(2);
    if (pwd_en_i) begin
      v = {v[MAX_BITS-35:0], 2'b00, pwd_i};
      n = n + LEN_W'(34);
    end
    if (write_i) begin
      // lone lock bit shifts data pairing by one
      v = {v[MAX_BITS-37:0], 1'b0, data_i, addr_i[2:0]};
      n = n + LEN_W'(36);
    end else if (addr_i != 8'hFF) begin
      v = {v[MAX_BITS-5:0], 1'b0, addr_i[2:0]};
      n = n + LEN_W'(4);
    end
    bits_o = v << (LEN_W'(MAX_BITS) - n);
    nsym_o = SYM_W'(n >> 1);
  end
endmodule

// File: rtl/lf_ppm_timer.sv
// Down-counter of tick pulses; expire_o marks the last tick of an interval.
module lf_ppm_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] dur_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= dur_i;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - W'(1);
  end

  assign expire_o = tick_i && (cnt_q == W'(1));
endmodule

// File: rtl/lf_ppm_tx.sv
module lf_ppm_tx
  import lf_ppm_pkg::*;
#(
  parameter int UNIT_US        = 8,
  parameter int T_SYM00        = 18,
  parameter int T_SYM01        = 34,
  parameter int T_SYM10        = 50,
  parameter int T_SYM11        = 66,
  parameter int T_GAP          = 20,
  parameter int T_START_GAP    = 31,
  parameter int T_READ_HOLD    = 210,
  parameter int T_POWERUP_US   = 5000,
  parameter int T_HOLD_WR_US   = 20000,
  parameter int T_HOLD_TEST_US = 5184
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        start_i,
  input  logic        write_i,
  input  logic        page_i,
  input  logic        test_i,
  input  logic        pwd_en_i,
  input  logic [31:0] pwd_i,
  input  logic [31:0] data_i,
  input  logic [7:0]  addr_i,
  output logic        carrier_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam int LONGEST = max2(max2(max2(T_POWERUP_US, T_HOLD_WR_US), T_HOLD_TEST_US),
                                max2(max2(T_READ_HOLD, T_SYM11), max2(T_START_GAP, T_GAP)) * UNIT_US);
  localparam int DUR_W = $clog2(LONGEST + 1);

  ppm_state_e          state_q, state_d;
  logic [MAX_BITS-1:0] sreg_q, pack_bits;
  logic [SYM_W-1:0]    left_q, pack_nsym;
  logic                wr_q, test_q, done_q;
  logic                load, expire;
  logic [DUR_W-1:0]    dur;

  lf_ppm_pack i_pack (
    .page_i, .test_i, .pwd_en_i, .write_i, .pwd_i, .data_i, .addr_i,
    .bits_o (pack_bits),
    .nsym_o (pack_nsym)
  );

  lf_ppm_timer #(.W(DUR_W)) i_timer (
    .clk_i, .rst_ni, .tick_i,
    .load_i   (load),
    .dur_i    (dur),
    .expire_o (expire)
  );

  function automatic logic [DUR_W-1:0] sym_dur(logic [1:0] code);
    case (code)
      2'b00:   return DUR_W'(T_SYM00 * UNIT_US);
      2'b01:   return DUR_W'(T_SYM01 * UNIT_US);
      2'b10:   return DUR_W'(T_SYM10 * UNIT_US);
      2'b11:   return DUR_W'(T_SYM11 * UNIT_US);
      default: return DUR_W'(T_SYM00 * UNIT_US);
    endcase
  endfunction

  logic [DUR_W-1:0] hold_dur;
  assign hold_dur = wr_q ? (test_q ? DUR_W'(T_HOLD_TEST_US) : DUR_W'(T_HOLD_WR_US))
                         : DUR_W'(T_READ_HOLD * UNIT_US);

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    dur     = '0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_POWER; load = 1'b1; dur = DUR_W'(T_POWERUP_US);
      end
      ST_POWER: if (expire) begin
        state_d = ST_SGAP; load = 1'b1; dur = DUR_W'(T_START_GAP * UNIT_US);
      end
      ST_SGAP: if (expire) begin
        state_d = ST_SYM; load = 1'b1; dur = sym_dur(sreg_q[MAX_BITS-1 -: 2]);
      end
      ST_SYM: if (expire) begin
        state_d = ST_GAP; load = 1'b1; dur = DUR_W'(T_GAP * UNIT_US);
      end
      ST_GAP: if (expire) begin
        load = 1'b1;
        if (left_q != '0) begin
          state_d = ST_SYM; dur = sym_dur(sreg_q[MAX_BITS-1 -: 2]);
        end else begin
          state_d = ST_HOLD; dur = hold_dur;
        end
      end
      ST_HOLD: if (expire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sreg_q  <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
      test_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_HOLD) && expire;
      if (state_q == ST_IDLE && start_i) begin
        sreg_q <= pack_bits;
        left_q <= pack_nsym;
        wr_q   <= write_i;
        test_q <= test_i;
      end else if (state_q == ST_SYM && expire) begin
        sreg_q <= {sreg_q[MAX_BITS-3:0], 2'b00};
        left_q <= left_q - SYM_W'(1);
      end
    end
  end

  assign carrier_o = (state_q == ST_POWER) || (state_q == ST_SYM) || (state_q == ST_HOLD);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
endmodule

// File: rtl/lf_ppm_checker.sv
module lf_ppm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic start_i,
  input logic carrier_o,
  input logic busy_o,
  input logic done_o
);
  AST_IDLE_NO_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !carrier_o) else $error("idle carrier"); // R8

  AST_START_POWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && carrier_o)) else $error("no power-up"); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("long done"); // R9

  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o) && $past(carrier_o))) else $error("done misplaced"); // R9

  AST_BUSY_FALLS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o) else $error("busy fell without done"); // R9

  AST_CARRIER_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(carrier_o) |-> ($past(tick_i) || $past(start_i))) else $error("carrier moved without tick"); // R11
endmodule

bind lf_ppm_tx lf_ppm_checker i_lf_ppm_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .start_i   (start_i),
  .carrier_o (carrier_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/test_lf_ppm_tx.sv
module test_lf_ppm_tx;
  localparam int U = 1, S00 = 18, S01 = 34, S10 = 50, S11 = 66, GAP = 20, SGAP = 31;
  localparam int RHOLD = 210, PWR = 40, HWR = 300, HTEST = 150;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, start_i = 1'b0;
  logic write_i = 0, page_i = 0, test_i = 0, pwd_en_i = 0;
  logic [31:0] pwd_i = '0, data_i = '0;
  logic [7:0] addr_i = '0;
  logic carrier_o, busy_o, done_o;

  always #5 clk = ~clk;

  lf_ppm_tx #(
    .UNIT_US(U), .T_SYM00(S00), .T_SYM01(S01), .T_SYM10(S10), .T_SYM11(S11),
    .T_GAP(GAP), .T_START_GAP(SGAP), .T_READ_HOLD(RHOLD),
    .T_POWERUP_US(PWR), .T_HOLD_WR_US(HWR), .T_HOLD_TEST_US(HTEST)
  ) i_lf_ppm_tx (.clk_i(clk), .*);

  int n_chk = 0, n_fail = 0, n_done = 0, tick_per = 1, tick_ph = 0, cyc = 0;
  bit exp_lvl[$];
  int exp_w[$];
  string exp_tag[$];

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(bit lvl, int w, string tag);
    exp_lvl.push_back(lvl); exp_w.push_back(w); exp_tag.push_back(tag);
  endtask

  function automatic int sym_w(bit [1:0] c);
    case (c) 2'b00: return S00 * U; 2'b01: return S01 * U; 2'b10: return S10 * U; default: return S11 * U; endcase
  endfunction

  // scoreboard driver: expected carrier runs from the requirements
  task automatic push_frame(bit wr, bit pg, bit tst, bit pe, bit [31:0] pw, bit [31:0] dt, bit [7:0] ad);
    bit b[$]; string t[$];
    b.push_back(0); b.push_back(0); t.push_back("R4"); t.push_back("R4");
    if (tst) begin b.push_back(0); b.push_back(1); end else begin b.push_back(1); b.push_back(pg); end
    t.push_back("R4"); t.push_back("R4");
    if (pe) begin
      b.push_back(0); b.push_back(0); t.push_back("R5"); t.push_back("R5");
      for (int i = 31; i >= 0; i--) begin b.push_back(pw[i]); t.push_back("R5"); end
    end
    if (wr) begin
      b.push_back(0); t.push_back("R6");
      for (int i = 31; i >= 0; i--) begin b.push_back(dt[i]); t.push_back("R6"); end
      for (int i = 2; i >= 0; i--) begin b.push_back(ad[i]); t.push_back("R6"); end
    end else if (ad != 8'hFF) begin
      b.push_back(0); t.push_back("R7");
      for (int i = 2; i >= 0; i--) begin b.push_back(ad[i]); t.push_back("R7"); end
    end
    push(1, PWR, "R1");
    push(0, SGAP * U, "R2");
    for (int i = 0; i < b.size(); i += 2) begin
      push(1, sym_w({b[i], b[i+1]}), t[i]);
      push(0, GAP * U, "R3");
    end
    push(1, wr ? (tst ? HTEST : HWR) : RHOLD * U, "R8");
  endtask

  // tick generator
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % tick_per;
    tick_i <= (tick_ph == 0);
  end

  // monitor
  bit prev = 0, skip_off = 1;
  int run = 0;
  always @(negedge clk) begin
    cyc++;
    if (done_o) n_done++;
    if (rst_ni) begin
      if (carrier_o !== prev) begin
        if (!prev && skip_off) skip_off = 0;
        else if (exp_lvl.size() == 0) chk(0, "R10", "unexpected carrier run", run, 0);
        else begin
          automatic bit l = exp_lvl.pop_front();
          automatic int w = exp_w.pop_front();
          automatic string tg = exp_tag.pop_front();
          chk(l == prev, tg, "run level", prev, l);
          chk(run >= (w - 1) * tick_per + 1 && run <= w * tick_per,
              (tick_per > 1) ? "R11" : tg, "run width", run, w * tick_per);
          if (prev && exp_lvl.size() == 0) begin
            chk(done_o === 1'b1, "R9", "done at final drop", done_o, 1);
            chk(busy_o === 1'b0, "R9", "busy at final drop", busy_o, 0);
            skip_off = 1;
          end else if (prev) chk(busy_o === 1'b1, "R9", "busy mid-frame", busy_o, 1);
        end
        run = 1;
        prev = carrier_o;
      end else run++;
    end
  end

  task automatic run_frame(bit wr, bit pg, bit tst, bit pe, bit [31:0] pw, bit [31:0] dt,
                           bit [7:0] ad, bit poke);
    int d0;
    push_frame(wr, pg, tst, pe, pw, dt, ad);
    d0 = n_done;
    @(negedge clk);
    write_i = wr; page_i = pg; test_i = tst; pwd_en_i = pe; pwd_i = pw; data_i = dt; addr_i = ad;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (poke) begin
      repeat (150) @(negedge clk);
      write_i = ~wr; page_i = ~pg; pwd_en_i = ~pe; data_i = ~dt; addr_i = 8'h02;
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      chk(busy_o === 1'b1, "R10", "busy after ignored start", busy_o, 1);
    end
    while (n_done == d0) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(carrier_o === 1'b0 && busy_o === 1'b0, "R10", "quiet after frame", carrier_o, 0);
    chk(n_done - d0 == 1, "R9", "done pulses per frame", n_done - d0, 1);
    chk(exp_lvl.size() == 0, "R3", "runs left in scoreboard", exp_lvl.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(carrier_o === 0 && busy_o === 0 && done_o === 0, "R1", "reset outputs",
        {carrier_o, busy_o, done_o}, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    run_frame(1, 0, 0, 0, 32'h0, 32'hA5C3_0F96, 8'h05, 0);  // R6 plain write
    run_frame(1, 1, 0, 1, 32'h1234_5678, 32'hFFFF_0000, 8'h07, 0); // R5 password write
    run_frame(1, 0, 1, 0, 32'h0, 32'h8000_0001, 8'h02, 0);  // R4 R8 test write
    run_frame(0, 1, 0, 0, 32'h0, 32'h0, 8'h03, 0);          // R7 read
    run_frame(0, 0, 0, 1, 32'hDEAD_BEEF, 32'h0, 8'hFF, 0);  // R7 pwd read, no address
    run_frame(0, 0, 0, 0, 32'h0, 32'h0, 8'hFF, 0);          // R7 opcode only
    run_frame(1, 1, 0, 0, 32'h0, 32'h3C3C_C3C3, 8'h04, 1);  // R10 start while busy
    tick_per = 3;
    run_frame(0, 1, 0, 1, 32'h0F0F_1234, 32'h0, 8'h06, 0);  // R11 slow tick
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    while (cyc < 190000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule